// File: doc/BRIEF.md
# Watchdog and Clock-Loss Reset Unit

This block supervises a processor subsystem in two ways. A software watchdog counts bus clock cycles and raises a reset request when software fails to service it in time. A clock-loss detector watches an oscillator-derived input and raises a separate reset request when that input stops toggling. Each source has its own one-cycle reset pulse. A sticky cause register remembers which source fired, and a vector output gives the restart address that matches the recorded cause.

Software programs the unit through a control byte written on `cfg_we_i`/`cfg_wdata_i`. Bit 7 turns clock-loss supervision on, and bits 2:0 select the watchdog period as a power-of-two number of bus cycles. Software keeps the watchdog alive by writing a two-byte key to the service port: first 0x55, then 0xAA. Any other order leaves the count running. The divisor exponents can be reduced by a build parameter so that short timeouts can be used for test. The number of idle reference cycles that counts as a lost clock is also a parameter.

Top module: `guard_reset_unit`

## Requirements
- R1: While `rst_n` is low and just after it is released, both reset pulses are 0, `cause_o` is 2'b00 and `vec_o` is 0xFFFE.
- R2: Control bits 2:0 select the watchdog period. Codes 1 to 7 give 2^E bus cycles, with E = 13, 15, 17, 19, 21, 22, 23 minus the parameter `SCALE_DROP`. The pulse appears that many cycles after the last restart edge.
- R3: Control code 000 stops the watchdog: no watchdog pulse is produced and service writes have no visible effect.
- R4: A service write of 0x55 followed by a service write of 0xAA restarts the watchdog count. The next pulse comes one full period after the 0xAA write.
- R5: A service write of 0xAA with no directly preceding 0x55, or a 0x55 followed by any value other than 0xAA or 0x55, does not restart the count.
- R6: Every control write restarts the watchdog count from zero.
- R7: With control bit 7 at 0 no clock-fail pulse is produced, however long the monitored input stays still.
- R8: With control bit 7 at 1, a clock-fail pulse appears `LOSS_LIMIT`+3 bus cycles after the last transition of `mon_clk_i` (two synchronizer stages plus one edge register). If supervision is enabled while the input is already still, the pulse appears `LOSS_LIMIT` cycles after the enabling write. A steadily toggling input never causes a pulse.
- R9: Each reset pulse (`wd_rst_o`, `cm_rst_o`) is exactly one bus cycle wide.
- R10: `cause_o[0]` (watchdog) and `cause_o[1]` (clock fail) set on their pulse and stay set until `rst_n` is asserted.
- R11: `vec_o` is 0xFFFC when `cause_o[1]` is set, else 0xFFFA when `cause_o[0]` is set, else 0xFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the reference for clock-loss timing |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| mon_clk_i | input | 1 | Supervised oscillator-derived input |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte: bit 7 clock-loss enable, bits 2:0 rate code |
| svc_we_i | input | 1 | Service key write strobe |
| svc_wdata_i | input | 8 | Service key byte |
| wd_rst_o | output | 1 | One-cycle watchdog timeout reset request |
| cm_rst_o | output | 1 | One-cycle clock-loss reset request |
| cause_o | output | 2 | Sticky cause flags: bit 0 watchdog, bit 1 clock fail |
| vec_o | output | 16 | Restart vector address for the recorded cause |

## Verification
The bench sweeps all seven rate codes and measures the exact cycle distance from the restart edge to the pulse. A design that selected the wrong exponent, or that was one cycle early or late, shows a different distance. It sends broken key sequences: a lone 0xAA, 0x55 followed by a stray byte, and random bytes. A tracker that did not clear its armed state on a stray byte would restart the count and move the pulse later. It stops the monitored input at a known cycle and enables supervision over an input that is already still, which exposes a synchronizer or idle counter of the wrong depth. It also checks that a mid-run reset clears the cause flags and that a clock fail takes vector priority over a watchdog timeout.

// File: rtl/guard_reset_pkg.sv
package guard_reset_pkg;
  localparam int MAX_EXP   = 23;
  localparam int CAUSE_N   = 2;
  localparam int CAUSE_WD  = 0;
  localparam int CAUSE_CLK = 1;
  localparam logic [15:0] VEC_POWER = 16'hFFFE;
  localparam logic [15:0] VEC_CLK   = 16'hFFFC;
  localparam logic [15:0] VEC_WD    = 16'hFFFA;

  // rate code -> power-of-two exponent of the bus clock divisor (0 = off)
  function automatic int rate_exp(input logic [2:0] code);
    case (code)
      3'd1:    return 13;
      3'd2:    return 15;
      3'd3:    return 17;
      3'd4:    return 19;
      3'd5:    return 21;
      3'd6:    return 22;
      3'd7:    return 23;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/guard_key_tracker.sv
module guard_key_tracker #(
  parameter int          KEY_W    = 8,
  parameter logic [7:0]  KEY_ARM  = 8'h55,
  parameter logic [7:0]  KEY_FIRE = 8'hAA
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] data_i,
  output logic             kick_o
);
  logic armed_q, armed_d;

  // next state: armed only by the first key, any other write disarms
  always_comb begin
    armed_d = armed_q;
    kick_o  = 1'b0;
    if (wr_i) begin
      if (data_i == KEY_W'(KEY_ARM)) begin
        armed_d = 1'b1;
      end else if (data_i == KEY_W'(KEY_FIRE) && armed_q) begin
        armed_d = 1'b0;
        kick_o  = 1'b1;
      end else begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/guard_wdog_counter.sv
module guard_wdog_counter
  import guard_reset_pkg::*;
#(
  parameter int SCALE_DROP = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_i,
  input  logic       restart_i,
  output logic       expire_o
);
  localparam int CNT_W = MAX_EXP + 1 - SCALE_DROP;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit_m1;
  logic             exp_q, exp_d;
  int               shamt;

  always_comb begin
    shamt    = (rate_i == 3'd0) ? 0 : (rate_exp(rate_i) - SCALE_DROP);
    limit_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);
  end

  // next state: restart or disabled holds zero, terminal count wraps and fires
  always_comb begin
    cnt_d = cnt_q + CNT_W'(1);
    exp_d = 1'b0;
    if (restart_i || rate_i == 3'd0) begin
      cnt_d = '0;
    end else if (cnt_q == limit_m1) begin
      cnt_d = '0;
      exp_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expire_o = exp_q;
endmodule

// File: rtl/guard_clk_loss.sv
module guard_clk_loss #(
  parameter int LOSS_LIMIT  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic mon_i,
  output logic fail_o
);
  localparam int IW = $clog2(LOSS_LIMIT + 1);

  logic [SYNC_STAGES:0] sync_q;
  logic                 edge_seen;
  logic [IW-1:0]        idle_q, idle_d;
  logic                 fail_q, fail_d;

  // synchronizer chain plus one extra stage for transition detection
  genvar g;
  generate
    for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= mon_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  assign edge_seen = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  // next state: idle run length saturates at the limit, one pulse on arrival
  always_comb begin
    idle_d = idle_q;
    fail_d = 1'b0;
    if (!en_i || edge_seen) begin
      idle_d = '0;
    end else if (idle_q != IW'(LOSS_LIMIT)) begin
      idle_d = idle_q + IW'(1);
      fail_d = (idle_q == IW'(LOSS_LIMIT - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      fail_q <= 1'b0;
    end else begin
      idle_q <= idle_d;
      fail_q <= fail_d;
    end
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/guard_reset_unit.sv
module guard_reset_unit
  import guard_reset_pkg::*;
#(
  parameter int SCALE_DROP = 0,
  parameter int LOSS_LIMIT = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mon_clk_i,
  input  logic         cfg_we_i,
  input  logic [7:0]   cfg_wdata_i,
  input  logic         svc_we_i,
  input  logic [7:0]   svc_wdata_i,
  output logic         wd_rst_o,
  output logic         cm_rst_o,
  output logic [CAUSE_N-1:0] cause_o,
  output logic [15:0]  vec_o
);
  localparam int MON_BIT = 7;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  // control register with explicit write enable
  logic       mon_en_q, mon_en_d;
  logic [2:0] rate_q, rate_d;
  always_comb begin
    mon_en_d = mon_en_q;
    rate_d   = rate_q;
    if (cfg_we_i) begin
      mon_en_d = cfg_wdata_i[MON_BIT];
      rate_d   = cfg_wdata_i[2:0];
    end
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mon_en_q <= 1'b0;
      rate_q   <= 3'd0;
    end else begin
      mon_en_q <= mon_en_d;
      rate_q   <= rate_d;
    end
  end

  logic kick, wd_fire, cm_fire;

  guard_key_tracker u_key (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_i   (svc_we_i),
    .data_i (svc_wdata_i),
    .kick_o (kick)
  );

  guard_wdog_counter #(.SCALE_DROP(SCALE_DROP)) u_wdog (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rate_i    (rate_q),
    .restart_i (kick | cfg_we_i),
    .expire_o  (wd_fire)
  );

  guard_clk_loss #(.LOSS_LIMIT(LOSS_LIMIT), .SYNC_STAGES(2)) u_loss (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .en_i   (mon_en_q),
    .mon_i  (mon_clk_i),
    .fail_o (cm_fire)
  );

  // sticky cause flags
  logic [CAUSE_N-1:0] cause_q, cause_d;
  always_comb begin
    cause_d = cause_q;
    if (wd_fire) cause_d[CAUSE_WD]  = 1'b1;
    if (cm_fire) cause_d[CAUSE_CLK] = 1'b1;
  end
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cause_q <= '0;
    else            cause_q <= cause_d;
  end

  // vector select, hardware failure ranks above software failure
  always_comb begin
    if (cause_q[CAUSE_CLK])     vec_o = VEC_CLK;
    else if (cause_q[CAUSE_WD]) vec_o = VEC_WD;
    else                        vec_o = VEC_POWER;
  end

  assign wd_rst_o = wd_fire;
  assign cm_rst_o = cm_fire;
  assign cause_o  = cause_q;
endmodule

// File: rtl/guard_reset_chk.sv
module guard_reset_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wd_rst,
  input logic        cm_rst,
  input logic [1:0]  cause,
  input logic [15:0] vec,
  input logic [2:0]  rate,
  input logic        mon_en
);
  p_wd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> !wd_rst);
  p_cm_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cm_rst |=> !cm_rst);
  p_wd_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == 3'd0) |=> !wd_rst);
  p_cm_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en |=> !cm_rst);
  p_wd_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> cause[0]);
  p_cm_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cm_rst |=> cause[1]);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cause[0] |=> cause[0]) and (cause[1] |=> cause[1]));
  p_vec_clk_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cause[1] |-> (vec == 16'hFFFC));
  p_vec_wd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cause == 2'b01) |-> (vec == 16'hFFFA));
endmodule

bind guard_reset_unit guard_reset_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wd_rst (wd_rst_o),
  .cm_rst (cm_rst_o),
  .cause  (cause_o),
  .vec    (vec_o),
  .rate   (rate_q),
  .mon_en (mon_en_q)
);

// File: tb/sim_guard_reset_unit.sv
`timescale 1ns/1ps
module sim_guard_reset_unit;
  localparam int DROP = 10;
  localparam int LOSS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mon_clk = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       svc_we = 1'b0;
  logic [7:0] svc_wdata = 8'h00;
  logic       wd_rst, cm_rst;
  logic [1:0] cause;
  logic [15:0] vec;

  int checks = 0;
  int fails  = 0;
  int unsigned cyc = 0;
  int unsigned last_tog = 0;
  logic tog_en = 1'b1;
  int tog_div = 0;

  guard_reset_unit #(.SCALE_DROP(DROP), .LOSS_LIMIT(LOSS)) u0 (
    .clk(clk), .rst_n(rst_n), .mon_clk_i(mon_clk),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .svc_we_i(svc_we), .svc_wdata_i(svc_wdata),
    .wd_rst_o(wd_rst), .cm_rst_o(cm_rst), .cause_o(cause), .vec_o(vec)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (tog_en) begin
      if (tog_div == 2) begin
        tog_div  <= 0;
        mon_clk  <= ~mon_clk;
        last_tog <= cyc;
      end else begin
        tog_div <= tog_div + 1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog expired: actual cycle %0d expected < 190000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int unsigned exp_of(input int code);
    int e[8] = '{0, 13, 15, 17, 19, 21, 22, 23};
    return e[code];
  endfunction

  function automatic int unsigned period_of(input int code);
    return 32'd1 << (exp_of(code) - DROP);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] v, output int unsigned mark);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    mark = cyc;
  endtask

  task automatic svc_write(input logic [7:0] v, output int unsigned mark);
    @(negedge clk); svc_we = 1'b1; svc_wdata = v;
    @(negedge clk); svc_we = 1'b0;
    mark = cyc;
  endtask

  task automatic service(output int unsigned mark);
    @(negedge clk); svc_we = 1'b1; svc_wdata = 8'h55;
    @(negedge clk); svc_wdata = 8'hAA;
    @(negedge clk); svc_we = 1'b0;
    mark = cyc;
  endtask

  // waits for a watchdog pulse, returns its cycle, then checks its width
  task automatic wait_wd(input int unsigned maxc, output int unsigned at);
    at = 0;
    for (int i = 0; i < int'(maxc); i++) begin
      @(negedge clk);
      if (wd_rst) begin at = cyc; break; end
    end
    @(negedge clk);
    check("R9 watchdog pulse width", wd_rst, 0);
  endtask

  task automatic wait_cm(input int unsigned maxc, output int unsigned at);
    at = 0;
    for (int i = 0; i < int'(maxc); i++) begin
      @(negedge clk);
      if (cm_rst) begin at = cyc; break; end
    end
    @(negedge clk);
    check("R9 clock-fail pulse width", cm_rst, 0);
  endtask

  initial begin
    int unsigned m, m2, at;
    int seen;
    void'($urandom(32'd2718));

    // R1 reset state
    @(negedge clk);
    check("R1 wd during reset", wd_rst, 0);
    check("R1 vec during reset", vec, 16'hFFFE);
    do_reset();
    check("R1 cause after reset", cause, 0);
    check("R1 vec after reset", vec, 16'hFFFE);
    check("R1 cm after reset", cm_rst, 0);

    // R2 every rate code, monitor on with a live input
    for (int c = 1; c <= 7; c++) begin
      cfg_write(8'h80 | 8'(c), m);
      wait_wd(period_of(c) + 20, at);
      check($sformatf("R2 period code %0d", c), at - m, period_of(c));
    end
    check("R10 watchdog cause set", cause, 2'b01);
    check("R11 watchdog vector", vec, 16'hFFFA);
    check("R8 live input no clock fail", cause[1], 0);

    // R6 control rewrite restarts
    cfg_write(8'h83, m);
    repeat (50) @(negedge clk);
    cfg_write(8'h83, m2);
    wait_wd(400, at);
    check("R6 rewrite restarts count", at - m2, period_of(3));

    // R4 random service timing
    for (int k = 0; k < 6; k++) begin
      int c = 1 + int'($urandom % 5);
      int w = int'($urandom % (period_of(c) / 2));
      cfg_write(8'h80 | 8'(c), m);
      repeat (w) @(negedge clk);
      service(m2);
      wait_wd(period_of(c) * 2, at);
      check($sformatf("R4 service restart code %0d", c), at - m2, period_of(c));
    end

    // R5 broken key sequences do not restart
    cfg_write(8'h83, m);
    svc_write(8'hAA, m2);
    svc_write(8'h55, m2);
    svc_write(8'h33, m2);
    svc_write(8'hAA, m2);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b = 8'($urandom);
      if (b == 8'h55 || b == 8'hAA) b = 8'h00;
      svc_write(8'h55, m2);
      svc_write(b, m2);
      svc_write(8'hAA, m2);
    end
    wait_wd(400, at);
    check("R5 bad keys leave count running", at - m, period_of(3));

    // R3 code 000 stops the watchdog, service has no effect
    cfg_write(8'h80, m);
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (wd_rst) seen = 1;
      if (i == 100) service(m2);
    end
    check("R3 disabled watchdog silent", seen, 0);

    // R10 cause cleared by reset, R7 monitor off ignores still input
    do_reset();
    check("R10 cause cleared", cause, 0);
    @(posedge clk); #1 tog_en = 1'b0;
    seen = 0;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (cm_rst) seen = 1;
    end
    check("R7 monitor off no clock fail", seen, 0);

    // R8 enable over a still input
    cfg_write(8'h80, m);
    wait_cm(LOSS + 10, at);
    check("R8 enable over still input", at - m, LOSS);
    check("R10 clock cause", cause, 2'b10);
    check("R11 clock vector", vec, 16'hFFFC);

    // R8 stop a live input at a known cycle
    do_reset();
    @(posedge clk); #1 tog_en = 1'b1;
    cfg_write(8'h80, m);
    seen = 0;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (cm_rst) seen = 1;
    end
    check("R8 toggling input no fail", seen, 0);
    @(posedge clk); #1 tog_en = 1'b0;
    wait_cm(LOSS + 20, at);
    check("R8 loss latency", at - last_tog, LOSS + 3);

    // R11 both causes: clock fail ranks first
    cfg_write(8'h81, m);
    wait_wd(40, at);
    check("R10 both causes", cause, 2'b11);
    check("R11 priority vector", vec, 16'hFFFC);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule